// File: doc/BRIEF.md
# Banked Scratchpad Read Conflict Serializer

This block serves one group of sixteen lane read requests against a word-organised scratchpad. The scratchpad is split into sixteen banks, and the bank of a word is taken from the low bits of its word address. Each bank can deliver one word per clock. When all active lanes land in different banks, the group finishes in a single service cycle. When lanes that hold different addresses fall in the same bank, they are served over successive cycles. Lanes that name exactly the same word share one read, and that word is returned to all of them.

A requester offers sixteen word addresses and an active-lane mask. The request is taken when `req_valid` and `req_ready` are both high. While the group is being served, `busy` is high and `req_ready` is low. In each service cycle, every bank serves the lowest-numbered lane that is still waiting on it. Every waiting lane that holds that same address completes in the same cycle. The per-lane results are collected in registers. One cycle after the last service cycle, `done` pulses high and the collected results are valid on `rd_data`.

The scratchpad holds fixed contents, so any read returns a known word. The word at address a is `((a << 16) | a) ^ 32'h5A0000C3`. For example, address 0x05 returns 0x5A0500C6.

Top module: `bank_conflict_rd`

## Requirements
- R1: Word address a maps to bank `a % 16`, which is the four low address bits. Two different addresses whose low four bits are equal conflict with each other. Addresses whose low four bits differ never conflict.
- R2: If every active lane hits a different bank, the request takes exactly one service cycle.
- R3: Lanes that hold an identical address are served together in one read and all receive the same word. A duplicated address adds no service cycle.
- R4: The number of service cycles equals the largest number of distinct addresses among the active lanes of any one bank, with a minimum of one. Examples: any odd stride needs 1 cycle, stride 2 needs 2 cycles, and stride 8 needs 8 cycles.
- R5: Each active lane receives the word stored at its address. That word is `((a << 16) | a) ^ 32'h5A0000C3`. An inactive lane receives zero.
- R6: After a request is taken, `busy` is high and `req_ready` is low until the request completes. Any `req_valid` offered during that time is ignored and has no effect on the results.
- R7: `done` is high for exactly one cycle. That cycle comes right after the last service cycle, and `busy` is low in it. Each lane's result on `rd_data` then stays unchanged until the next request is taken.
- R8: A request with an all-zero mask completes after one service cycle and returns all-zero data.
- R9: After reset, `busy` and `done` are low, `req_ready` is high, and `rd_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can take a request |
| req_mask | input | 16 | Active-lane mask; bit t enables lane t |
| req_addr | input | 128 | Lane t word address in bits [8t+7:8t] |
| rd_data | output | 512 | Lane t result in bits [32t+31:32t] |
| done | output | 1 | Single-cycle pulse: all results are valid |
| busy | output | 1 | A request is being served |

## Verification
The acceptance edge is the rising edge at which `req_valid` and `req_ready` are both high. If a request needs K service cycles, `done` rises at the K-th rising edge after the acceptance edge. At that same edge the last lane results land in their registers. The bench records the cycle number of the acceptance edge and computes K on its own by counting distinct addresses per bank. Its monitor samples on falling edges, so it reads `done` and `rd_data` half a period after the edge that set them, and it compares the measured distance against K. The checks that ignored requests have no effect, and that results are held afterwards, are made on falling edges between that edge and the next acceptance.

// File: rtl/bank_conflict_rd.sv
module bank_conflict_rd #(
  parameter int LANES = 16,
  parameter int NBANK = 16,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  output logic [LANES*DW-1:0] rd_data,
  output logic                done,
  output logic                busy
);
  localparam int BW = $clog2(NBANK);

  logic [AW-1:0]    addr_q [LANES];
  logic [DW-1:0]    data_q [LANES];
  logic [LANES-1:0] pend_q;
  logic [LANES-1:0] lead;
  logic [LANES-1:0] fin;
  logic             accept;

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    logic [31:0] w;
    w = ((32'(a) << 16) | 32'(a)) ^ 32'h5A0000C3;
    return DW'(w);
  endfunction

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    lead = '0;
    fin  = '0;
    for (int t = 0; t < LANES; t++) begin
      lead[t] = pend_q[t];
      for (int j = 0; j < t; j++)
        if (pend_q[j] && addr_q[j][BW-1:0] == addr_q[t][BW-1:0]) lead[t] = 1'b0;
    end
    for (int t = 0; t < LANES; t++)
      for (int j = 0; j <= t; j++)
        if (pend_q[t] && lead[j] && addr_q[j] == addr_q[t]) fin[t] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      pend_q <= '0;
      for (int t = 0; t < LANES; t++) begin
        addr_q[t] <= '0;
        data_q[t] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        pend_q <= req_mask;
        for (int t = 0; t < LANES; t++) begin
          addr_q[t] <= req_addr[t*AW +: AW];
          data_q[t] <= '0;
        end
      end else if (busy) begin
        pend_q <= pend_q & ~fin;
        for (int t = 0; t < LANES; t++)
          if (fin[t]) data_q[t] <= word_at(addr_q[t]);
        if ((pend_q & ~fin) == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign rd_data[g*DW +: DW] = data_q[g];
  end
endmodule

// File: rtl/bank_conflict_rd_chk.sv
module bank_conflict_rd_chk #(
  parameter int LANES = 16,
  parameter int NBANK = 16,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [LANES-1:0]    req_mask,
  input logic [LANES*AW-1:0] req_addr,
  input logic [LANES*DW-1:0] rd_data,
  input logic                done,
  input logic                busy
);
  localparam int CW = $clog2(LANES + 2);
  logic [CW-1:0]    svc_cnt;
  logic [LANES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_cnt <= '0;
      mask_q  <= '0;
    end else begin
      svc_cnt <= busy ? svc_cnt + 1'b1 : '0;
      if (req_valid && req_ready) mask_q <= req_mask;
    end
  end

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_valid && req_ready)) |=> $stable(rd_data));

  // R4
  svc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(svc_cnt) < LANES));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R5
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mask_q[g]) |-> (rd_data[g*DW +: DW] == '0));
  end
endmodule

bind bank_conflict_rd bank_conflict_rd_chk #(
  .LANES(LANES), .NBANK(NBANK), .AW(AW), .DW(DW)
) u_chk (.*);

// File: tb/bank_conflict_rd_bench.sv
`timescale 1ns/1ps
module bank_conflict_rd_bench;
  localparam int L = 16;
  localparam int A = 8;
  localparam int D = 32;

  typedef struct {
    logic [L*D-1:0] exp;
    int             k;
    int             acc;
    string          tag;
  } item_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic [L-1:0]   req_mask = '0;
  logic [L*A-1:0] req_addr = '0;
  logic           req_ready, done, busy;
  logic [L*D-1:0] rd_data;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  item_t q[$];

  bank_conflict_rd u_bank_conflict_rd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .rd_data(rd_data),
    .done(done), .busy(busy));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] word_of(input logic [7:0] a);
    return ({16'h0000, 8'h00, a} << 16 | {24'h0, a}) ^ 32'h5A0000C3;
  endfunction

  function automatic logic [L*A-1:0] stride(input int base, input int s);
    logic [L*A-1:0] v;
    for (int t = 0; t < L; t++) v[t*A +: A] = 8'(base + s * t);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic send(input logic [L-1:0] m, input logic [L*A-1:0] av,
                      input string tag, input bit junk);
    item_t it;
    int    k;
    k = 0;
    it.exp = '0;
    it.tag = tag;
    for (int t = 0; t < L; t++)
      if (m[t]) it.exp[t*D +: D] = word_of(av[t*A +: A]);
    for (int b = 0; b < 16; b++) begin
      int n;
      n = 0;
      for (int t = 0; t < L; t++) begin
        bit seen;
        seen = 1'b0;
        for (int j = 0; j < t; j++)
          if (m[j] && av[j*A +: A] == av[t*A +: A]) seen = 1'b1;
        if (m[t] && !seen && int'(av[t*A +: 4]) == b) n++;
      end
      if (n > k) k = n;
    end
    it.k = (k == 0) ? 1 : k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_mask  = m;
    req_addr  = av;
    it.acc = cyc + 1;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    if (junk) begin
      for (int i = 0; i < 3; i++) begin
        req_valid = 1'b1;
        req_mask  = ~m;
        req_addr  = stride(200 + i, 1);
        check(req_ready == 1'b0, "R6", "req_ready while busy", req_ready, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R6", "unexpected done", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(cyc - it.acc == it.k, "R4", {it.tag, " service cycles"}, cyc - it.acc, it.k);
        check(busy == 1'b0, "R7", "busy during done", busy, 0);
        for (int t = 0; t < L; t++)
          check(rd_data[t*D +: D] == it.exp[t*D +: D], "R5", {it.tag, " lane data"},
                rd_data[t*D +: D], it.exp[t*D +: D]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [L*D-1:0] snap;
    logic [L*A-1:0] av;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9", "busy after reset", busy, 0);
    check(done == 1'b0, "R9", "done after reset", done, 0);
    check(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
    check(rd_data == '0, "R9", "data after reset", 0, 0);
    rst_n = 1'b1;
    // R2: stride 1 and odd strides, one cycle
    send('1, stride(0, 1), "R2 stride1", 1'b0);
    send('1, stride(7, 3), "R2 stride3", 1'b0);
    send('1, stride(5, 5), "R2 stride5", 1'b0);
    // R4 and R1: stride 2 and stride 8 conflicts
    send('1, stride(0, 2), "R4 stride2", 1'b0);
    send('1, stride(3, 8), "R4 stride8", 1'b1);
    // R1: same low bits, different high bits conflict
    av = stride(0, 1);
    av[A +: A] = 8'h10;
    av[2*A +: A] = 8'h20;
    send('1, av, "R1 high-bit alias", 1'b0);
    // R3: broadcast of a single word
    send('1, stride(42, 0), "R3 all same", 1'b0);
    av = stride(0, 16);
    for (int t = 0; t < 8; t++) av[t*A +: A] = 8'h33;
    send('1, av, "R3 mixed broadcast", 1'b0);
    // R5: partial masks
    send(16'hA5C3, stride(1, 2), "R5 partial mask", 1'b0);
    // R8: empty mask
    send('0, stride(9, 1), "R8 empty mask", 1'b0);
    // R7: results held after done
    send(16'h00FF, stride(4, 4), "R7 hold", 1'b0);
    snap = rd_data;
    repeat (4) @(negedge clk);
    check(rd_data == snap, "R7", "held data", 0, 0);
    check(done == 1'b0, "R7", "done stays low", done, 0);
    // R4: random patterns
    for (int i = 0; i < 24; i++) begin
      logic [L*A-1:0] r;
      for (int t = 0; t < L; t++) r[t*A +: A] = 8'($urandom_range(0, 47));
      send(16'($urandom), r, "R4 random", 1'b0);
    end
    summary();
    $finish;
  end
endmodule